// File: doc/BRIEF.md
# Serial LED Output Shifter

This block drives a 17-bit LED word into an external chain of shift-register chips over two wires: a serial clock and a serial data line. A third line, a one-cycle latch strobe, transfers the chain contents to the chip outputs when the chain has output latches. Each transfer sends all 17 bits, most significant bit first. The serial clock is a division of the system clock. The point at which data changes after each falling clock edge can be moved with a delay setting.

The block has two ways to start a transfer. In direct mode, software writes a word and the transfer starts at once. In pulse mode, the block watches the upper 17 channels of a waveform generator bank. It sends the channel word whenever that word differs from the last word it sent in pulse mode. That stored word is cleared to zero at reset, and direct transfers do not update it. So a chain holding stale data is not cleared when pulse mode is entered with all channels low. Software must first send an all-zero word in direct mode.

While a transfer is running, the busy output is high. During that time, data and configuration writes are dropped.

Top module: `sled_shifter`

## Requirements
- R1: After reset, busy_o, sclk_o, sdata_o and latch_o are all low. The divider, delay and mode settings are all zero.
- R2: A write with wr_sel_i=0, accepted while idle and not in pulse mode, shifts wr_data_i[16:0] out most significant bit first. The chain receives one bit on each rising edge of sclk_o.
- R3: busy_o rises in the cycle after an accepted start. It stays high for exactly 17*P+1 cycles, where P is the serial clock period in system cycles.
- R4: The divider field is wr_data_i[1:0] under wr_sel_i=1. It sets P = 4 << field, so a value of 3 gives 32. sclk_o is high during the second half of each bit period.
- R5: The delay field is wr_data_i[3:0] under wr_sel_i=2. With a value n, sdata_o changes n+1 cycles after sclk_o falls. Values above P/2-1 act as P/2-1.
- R6: A data write made while busy_o is high is dropped. This includes a write in the final latch cycle. No second transfer follows.
- R7: Divider, delay and mode writes made while busy_o is high are dropped. This includes a write that would enter pulse mode.
- R8: Pulse mode is wr_data_i[1] under wr_sel_i=3. In this mode, a transfer of gen_word_i starts whenever gen_word_i differs from the last word sent in pulse mode. That stored word resets to zero, so an all-zero word sends nothing after reset.
- R9: Direct transfers leave the stored pulse-mode word unchanged. After a direct non-zero transfer, entering pulse mode with an all-zero gen_word_i leaves the chain holding the old word.
- R10: If mode bit wr_data_i[0] under wr_sel_i=3 is clear, latch_o pulses high for one cycle after the 17th bit. If the bit is set, for a chain without output latches, latch_o stays low.
- R11: Data writes made in pulse mode are dropped.
- R12: If gen_word_i changes during a transfer, the new word is sent in a transfer that starts right after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 data, 1 divider, 2 delay, 3 mode |
| wr_data_i | input | 17 | Write value |
| gen_word_i | input | 17 | Generator channel word used in pulse mode |
| busy_o | output | 1 | Transfer in progress |
| sclk_o | output | 1 | Serial clock to the chain |
| sdata_o | output | 1 | Serial data to the chain |
| latch_o | output | 1 | One-cycle strobe that latches the chain outputs |

## Verification
Two events can fall in the same cycle: the end of a transfer, and a new request from software or the generator word.

To provoke this, the bench watches for the latch strobe. It issues a data write in exactly that cycle, and expects the write to be dropped, with no further transfer. It also changes the generator word halfway through a pulse-mode transfer, and expects a second transfer to begin right after the latch cycle.

A scoreboard queue holds every word the bench expects to appear. A monitor compares each queued word against the modelled chain whenever busy falls. Any transfer with no queued word, or any word left in the queue at the end, is reported as a failure.

// File: rtl/sled_pkg.sv
package sled_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_DLY  = 2'd2,
    SEL_MODE = 2'd3
  } sled_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_LATCH = 2'd2
  } sled_st_e;

  typedef struct packed {
    logic pulse;
    logic hc164;
  } sled_mode_t;
endpackage

// File: rtl/sled_clkgen.sv
module sled_clkgen #(
  parameter int DIV_W    = 2,
  parameter int DLY_W    = 4,
  parameter int BASE_DIV = 4,
  parameter int PW       = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             sclk_o,
  output logic             data_ev_o,
  output logic             bit_end_o
);
  logic [PW-1:0] period, half, dly_ext, dly_eff, cnt_q;

  assign period  = PW'(BASE_DIV) << div_i;
  assign half    = period >> 1;
  assign dly_ext = PW'(dly_i);
  // delay clamped to half-1 so data settles before the rising edge
  assign dly_eff = (dly_ext >= half) ? half - PW'(1) : dly_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= (cnt_q == period - PW'(1)) ? '0 : cnt_q + PW'(1);
  end

  assign sclk_o    = run_i && (cnt_q >= half);
  assign data_ev_o = run_i && (cnt_q == dly_eff);
  assign bit_end_o = run_i && (cnt_q == period - PW'(1));

  p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < period));
endmodule

// File: rtl/sled_serializer.sv
module sled_serializer import sled_pkg::*; #(
  parameter int WORD_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              hc164_i,
  input  logic              data_ev_i,
  input  logic              bit_end_i,
  output logic              busy_o,
  output logic              run_o,
  output logic              sdata_o,
  output logic              latch_o
);
  localparam int BW = $clog2(WORD_W);
  localparam logic [BW-1:0] LAST = BW'(WORD_W - 1);

  sled_st_e          st_q;
  logic [WORD_W-1:0] shreg_q;
  logic [BW-1:0]     bitcnt_q;
  logic              sdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      shreg_q  <= '0;
      bitcnt_q <= '0;
      sdata_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q     <= ST_RUN;
          shreg_q  <= word_i;
          bitcnt_q <= '0;
        end
        ST_RUN: begin
          if (data_ev_i) sdata_q <= shreg_q[WORD_W-1];
          if (bit_end_i) begin
            shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
            if (bitcnt_q == LAST) st_q <= ST_LATCH;
            else                  bitcnt_q <= bitcnt_q + BW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign run_o   = (st_q == ST_RUN);
  assign sdata_o = sdata_q;
  assign latch_o = (st_q == ST_LATCH) && !hc164_i;

  p_bitcnt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bitcnt_q <= LAST);
  p_start_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (st_q == ST_IDLE));
  p_latch_once_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> (!latch_o && !busy_o));
endmodule

// File: rtl/sled_pulse_track.sv
module sled_pulse_track #(
  parameter int WORD_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              take_i,
  output logic              req_o
);
  logic [WORD_W-1:0] last_q;

  // only pulse-mode transfers update the reference word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= '0;
    else if (take_i) last_q <= word_i;
  end

  assign req_o = en_i && (word_i != last_q);

  p_take_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> req_o);
endmodule

// File: rtl/sled_shifter.sv
module sled_shifter import sled_pkg::*; #(
  parameter int WORD_W   = 17,
  parameter int DIV_W    = 2,
  parameter int DLY_W    = 4,
  parameter int BASE_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [WORD_W-1:0] gen_word_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              latch_o
);
  localparam int MAX_PERIOD = BASE_DIV << ((1 << DIV_W) - 1);
  localparam int PW         = $clog2(MAX_PERIOD) + 1;

  logic [DIV_W-1:0] div_q;
  logic [DLY_W-1:0] dly_q;
  sled_mode_t       mode_q;
  sled_sel_e        sel;
  logic             cfg_ok, start_direct, pulse_req, take, start, run;
  logic             data_ev, bit_end;
  logic [WORD_W-1:0] word;

  assign sel    = sled_sel_e'(wr_sel_i);
  assign cfg_ok = wr_en_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      dly_q  <= '0;
      mode_q <= '0;
    end else if (cfg_ok) begin
      if (sel == SEL_DIV)  div_q  <= wr_data_i[DIV_W-1:0];
      if (sel == SEL_DLY)  dly_q  <= wr_data_i[DLY_W-1:0];
      if (sel == SEL_MODE) mode_q <= '{pulse: wr_data_i[1], hc164: wr_data_i[0]};
    end
  end

  assign start_direct = cfg_ok && (sel == SEL_DATA) && !mode_q.pulse;
  assign take         = pulse_req && !busy_o;
  assign start        = start_direct || take;
  assign word         = mode_q.pulse ? gen_word_i : wr_data_i;

  sled_pulse_track #(.WORD_W(WORD_W)) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mode_q.pulse),
    .word_i (gen_word_i),
    .take_i (take),
    .req_o  (pulse_req)
  );

  sled_clkgen #(.DIV_W(DIV_W), .DLY_W(DLY_W), .BASE_DIV(BASE_DIV), .PW(PW)) u_clkgen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (start),
    .div_i     (div_q),
    .dly_i     (dly_q),
    .sclk_o    (sclk_o),
    .data_ev_o (data_ev),
    .bit_end_o (bit_end)
  );

  sled_serializer #(.WORD_W(WORD_W)) u_ser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .word_i    (word),
    .hc164_i   (mode_q.hc164),
    .data_ev_i (data_ev),
    .bit_end_i (bit_end),
    .busy_o    (busy_o),
    .run_o     (run),
    .sdata_o   (sdata_o),
    .latch_o   (latch_o)
  );

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && !latch_o));
  p_data_setup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> !$past(sclk_o));
  p_cfg_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(div_q) && $stable(dly_q) && $stable(mode_q)));
  p_pulse_no_direct_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.pulse && !busy_o && !pulse_req) |=> !busy_o);
endmodule

// File: tb/sled_shifter_test.sv
module sled_shifter_test;
  localparam int W = 17;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [1:0]   wr_sel_i = '0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] gen_word_i = '0;
  logic         busy_o, sclk_o, sdata_o, latch_o;

  sled_shifter uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .gen_word_i (gen_word_i),
    .busy_o     (busy_o),
    .sclk_o     (sclk_o),
    .sdata_o    (sdata_o),
    .latch_o    (latch_o)
  );

  int checks = 0, fails = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] chain = '0, latched = '0, e_w;
  int shifts = 0, latches = 0, meas_dly = 0, meas_per = 0, k_fall = 0, k_rise = 0;
  bit rise_seen = 0;
  logic p_sclk = 0, p_sdata = 0, p_busy = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // chain model and scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      k_fall++;
      k_rise++;
      if (p_sclk && !sclk_o) k_fall = 0;
      if (sdata_o !== p_sdata && busy_o) meas_dly = k_fall;
      if (!p_sclk && sclk_o) begin
        chain = {chain[W-2:0], sdata_o};
        if (rise_seen) meas_per = k_rise;
        rise_seen = 1;
        k_rise = 0;
      end
      if (latch_o) begin
        latched = chain;
        latches++;
      end
      if (p_busy && !busy_o) begin
        shifts++;
        rise_seen = 0;
        if (exp_q.size() == 0) chk(0, "R6 unexpected transfer", int'(chain), 0);
        else begin
          e_w = exp_q.pop_front();
          chk(chain == e_w, "R2 chain word", int'(chain), int'(e_w));
        end
      end
      p_sclk = sclk_o;
      p_sdata = sdata_o;
      p_busy = busy_o;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    @(negedge clk);
    wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic settle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic direct(input logic [W-1:0] w, input int per, input string req);
    int n;
    exp_q.push_back(w);
    wr(2'd0, w);
    wait_idle(n);
    chk(n == 17 * per + 1, req, n, 17 * per + 1);
    settle(2);
  endtask

  initial begin
    int s0, l0, n;
    settle(3);
    chk(!busy_o, "R1 busy", busy_o, 0);
    chk(!sclk_o, "R1 sclk", sclk_o, 0);
    chk(!sdata_o, "R1 sdata", sdata_o, 0);
    chk(!latch_o, "R1 latch", latch_o, 0);
    rst_ni = 1;
    settle(2);

    // R2 R3 R10: default divider, latched word
    direct(17'h1A5C3, 4, "R3 busy length div0");
    chk(latched == 17'h1A5C3, "R10 latched word", int'(latched), 'h1A5C3);
    chk(latches == 1, "R10 latch count", latches, 1);

    // R4 R5: divide-by-32, delay 5
    wr(2'd1, 17'd3);
    wr(2'd2, 17'd5);
    direct(17'h15555, 32, "R3 busy length div3");
    chk(meas_per == 32, "R4 sclk period", meas_per, 32);
    chk(meas_dly == 6, "R5 delay n+1", meas_dly, 6);

    // R5 clamp: div 0, delay 15 -> acts as 1
    wr(2'd1, 17'd0);
    wr(2'd2, 17'd15);
    direct(17'h0AAAA, 4, "R3 busy length div0 b");
    chk(meas_dly == 2, "R5 delay clamp", meas_dly, 2);
    chk(meas_per == 4, "R4 sclk period div0", meas_per, 4);
    wr(2'd2, 17'd0);

    // R6 R7: writes during a transfer
    gen_word_i = 17'h000F0;
    s0 = shifts;
    exp_q.push_back(17'h0C0C3);
    wr(2'd0, 17'h0C0C3);
    wr(2'd0, 17'h1FFFF);
    wr(2'd3, 17'd2);
    wr(2'd1, 17'd3);
    wait_idle(n);
    settle(30);
    chk(shifts - s0 == 1, "R6 R7 one transfer", shifts - s0, 1);
    direct(17'h00101, 4, "R7 divider write dropped");

    // R9 R8: direct transfer leaves tracker at zero
    direct(17'h1FFFF, 4, "R3 busy length c");
    gen_word_i = '0;
    s0 = shifts;
    wr(2'd3, 17'd2);
    settle(40);
    chk(shifts == s0, "R8 zero word sends nothing", shifts - s0, 0);
    chk(chain == 17'h1FFFF, "R9 stale chain kept", int'(chain), 'h1FFFF);

    // R11: data write in pulse mode
    wr(2'd0, 17'h00001);
    settle(40);
    chk(shifts == s0, "R11 data write dropped", shifts - s0, 0);

    // R8: generator change triggers transfer
    exp_q.push_back(17'h12345);
    @(negedge clk) gen_word_i = 17'h12345;
    settle(2);
    wait_idle(n);
    settle(3);
    chk(shifts - s0 == 1, "R8 pulse transfer", shifts - s0, 1);

    // R12: change during a transfer
    s0 = shifts;
    exp_q.push_back(17'h00111);
    @(negedge clk) gen_word_i = 17'h00111;
    settle(10);
    exp_q.push_back(17'h00222);
    gen_word_i = 17'h00222;
    wait_idle(n);
    settle(1);
    wait_idle(n);
    settle(3);
    chk(shifts - s0 == 2, "R12 follow-up transfer", shifts - s0, 2);
    exp_q.push_back(17'h00000);
    @(negedge clk) gen_word_i = '0;
    settle(2);
    wait_idle(n);
    settle(3);
    chk(chain == 17'h0, "R8 zero after non-zero", int'(chain), 0);

    // R10: chain without latches
    wr(2'd3, 17'd1);
    l0 = latches;
    direct(17'h0F0F0, 4, "R3 busy length hc");
    chk(latches == l0, "R10 no strobe", latches - l0, 0);

    // R6: data write in the latch cycle
    wr(2'd3, 17'd0);
    s0 = shifts;
    exp_q.push_back(17'h13579);
    wr(2'd0, 17'h13579);
    while (!latch_o) @(negedge clk);
    wr_en_i = 1; wr_sel_i = 2'd0; wr_data_i = 17'h00001;
    @(negedge clk);
    wr_en_i = 0;
    settle(30);
    chk(shifts - s0 == 1, "R6 latch-cycle write dropped", shifts - s0, 1);
    chk(!busy_o, "R6 idle after", busy_o, 0);

    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule